// File: doc/BRIEF.md
# Serial-Bus Memory Protection Configuration Engine

This block is a two-wire serial-bus slave that sits beside a small serial memory and owns that memory's protection settings. It holds a protected range, given as a 4-bit starting block and a 4-bit block count, and a 4-bit high-endurance block number. A bus master reaches these settings through configuration transactions. A flag in the first address byte marks a transaction as a configuration access. The top two bits of the command byte that follows select one of four operations: protection write, protection read, endurance write or endurance read.

The block samples the synchronised SCL and SDA lines with its own clock. It detects start and stop conditions and shifts bytes in and out. It acknowledges by pulling SDA low through an output-enable, which the board turns into an open-drain driver. Write commands are staged while the bytes arrive. They are copied into the setting registers only when a stop condition ends the transaction cleanly. The current settings are also brought out as plain outputs for the memory array logic.

Top module: `i2c_cfg_engine`

## Requirements
- R1: The first byte after a start is taken as the control byte. It matches only if bits 7..4 are 1010 and bits 3..1 equal `addr_sel`. Bit 0 is the direction (0 = write, 1 = read). A control byte that does not match is not acknowledged, and the transaction changes no setting.
- R2: In a matched write transaction, the block acknowledges every received byte by holding SDA low during the ninth clock.
- R3: Protection write. Address byte 1 has bit 7 = 1 and carries the starting block in bits 4..1. The command byte has the form 10xxNNNN, where NNNN is the block count. After the stop, `prot_start` and `prot_cnt` take these values.
- R4: Endurance write. Address byte 1 has bit 7 = 1 and carries the block in bits 4..1. The command byte has the form 00xx0000. After the stop, `he_blk` takes the block number. An endurance command byte whose low nibble is not 0000 is acknowledged but changes nothing.
- R5: Protection read. Command byte 11xxxxxx, then a repeated start and a matching control byte with bit 0 = 1. The block returns byte {1111, starting block} and, if the master acknowledges that byte, byte {1111, block count}. Bits go out MSB first.
- R6: Endurance read. Command byte 01xxxxxx, then a repeated start and a read control byte. The block returns one byte {1111, `he_blk`}.
- R7: Staged write values reach the settings only on a stop. A repeated start in place of the stop, or a stop that comes before the command byte has been received, leaves all settings unchanged.
- R8: After reset, `prot_start` = 0, `prot_cnt` = 0, `he_blk` = 0 and `sda_oe` = 0. `sda_oe` is 0 whenever the block is not acknowledging or sending a 0 bit.
- R9: A read control byte is acknowledged only when a configuration read command is pending in the current transaction. Otherwise it is left unacknowledged. A not-acknowledge from the master ends the data phase and releases SDA.
- R10: When bit 7 of address byte 1 is 0, the transaction is a normal access. Its bytes are acknowledged and no setting changes.
- R11: `sda_oe` changes only while SCL is low. A falling SDA while SCL is high is a start condition, and a rising SDA while SCL is high is a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel | input | 3 | Device-select strap pins |
| sda_oe | output | 1 | 1 = pull SDA low |
| prot_start | output | 4 | First protected block |
| prot_cnt | output | 4 | Number of protected blocks |
| he_blk | output | 4 | High-endurance block number |

## Verification
The bench builds the block with its default parameters: a two-stage line synchroniser and the 1010 device code. Its bus quarter-period is five clocks, so the three-clock input latency fits inside every SCL low phase. With these values, repeated starts placed one clock quarter apart and changes to the strap pins between transactions are both within reach. Reading back through the configuration read commands lets the bench check each write and each ignored write at the bus, and also at the setting outputs.

// File: rtl/i2ccfg_pkg.sv
package i2ccfg_pkg;
  localparam int BLK_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_st_e;

  // command byte bits 7..6
  typedef enum logic [1:0] {
    OP_END_WR  = 2'b00,
    OP_END_RD  = 2'b01,
    OP_PROT_WR = 2'b10,
    OP_PROT_RD = 2'b11
  } cfg_op_e;

  function automatic logic ctrl_match(input logic [7:0] b, input logic [3:0] code,
                                      input logic [2:0] pins);
    return (b[7:4] == code) && (b[3:1] == pins);
  endfunction

  function automatic logic write_cmd_ok(input logic [7:0] cmd);
    logic ok;
    case (cfg_op_e'(cmd[7:6]))
      OP_PROT_WR: ok = 1'b1;
      OP_END_WR:  ok = (cmd[3:0] == 4'h0);
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [7:0] reply_byte(input logic prot, input logic second,
                                            input logic [BLK_W-1:0] start,
                                            input logic [BLK_W-1:0] cnt,
                                            input logic [BLK_W-1:0] he);
    logic [BLK_W-1:0] nib;
    if (prot) nib = second ? cnt : start;
    else      nib = he;
    return {4'hF, nib};
  endfunction
endpackage

// File: rtl/i2ccfg_line_sync.sv
module i2ccfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ccfg_regs.sv
module i2ccfg_regs
  import i2ccfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             commit_prot,
  input  logic [BLK_W-1:0] blk_arg,
  input  logic [BLK_W-1:0] cnt_arg,
  output logic [BLK_W-1:0] prot_start,
  output logic [BLK_W-1:0] prot_cnt,
  output logic [BLK_W-1:0] he_blk
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prot_start <= '0;
      prot_cnt   <= '0;
      he_blk     <= '0;
    end else if (commit) begin
      if (commit_prot) begin
        prot_start <= blk_arg;
        prot_cnt   <= cnt_arg;
      end else begin
        he_blk <= blk_arg;
      end
    end
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import i2ccfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       addr_sel,
  output logic             sda_oe,
  output logic [BLK_W-1:0] prot_start,
  output logic [BLK_W-1:0] prot_cnt,
  output logic [BLK_W-1:0] he_blk
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX   = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2ccfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  bus_st_e          state;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       rx_sr, tx_sr;
  logic [2:0]       byte_idx;
  logic             rd_mode, rd_pending, rd_prot;
  logic             wr_pending, wr_prot, cfg_sel;
  logic [BLK_W-1:0] arg_blk, arg_cnt;
  logic             tx_last, mack_ok, sda_oe_q;

  // named events for the checker
  logic byte_evt, ctrl_ok, byte_ack, go_read, in_idle, tx_active, commit;
  logic [7:0] first_reply, second_reply;

  assign byte_evt  = (state == ST_RX) && scl_fall && (bitcnt == BITS_FULL);
  assign ctrl_ok   = ctrl_match(rx_sr, DEV_CODE, addr_sel);
  assign in_idle   = (state == ST_IDLE);
  assign tx_active = (state == ST_TX);
  assign commit    = stop_evt && wr_pending;
  assign first_reply  = reply_byte(rd_prot, 1'b0, prot_start, prot_cnt, he_blk);
  assign second_reply = reply_byte(rd_prot, 1'b1, prot_start, prot_cnt, he_blk);

  always_comb begin
    byte_ack = 1'b1;
    go_read  = 1'b0;
    if (byte_idx == 3'd0) begin
      if (!ctrl_ok)      byte_ack = 1'b0;
      else if (rx_sr[0]) begin
        byte_ack = rd_pending;
        go_read  = rd_pending;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      byte_idx   <= '0;
      rd_mode    <= 1'b0;
      rd_pending <= 1'b0;
      rd_prot    <= 1'b0;
      wr_pending <= 1'b0;
      wr_prot    <= 1'b0;
      cfg_sel    <= 1'b0;
      arg_blk    <= '0;
      arg_cnt    <= '0;
      tx_last    <= 1'b0;
      mack_ok    <= 1'b0;
      sda_oe_q   <= 1'b0;
    end else if (start_evt) begin
      state      <= ST_RX;
      bitcnt     <= '0;
      byte_idx   <= '0;
      rd_mode    <= 1'b0;
      wr_pending <= 1'b0;
      sda_oe_q   <= 1'b0;
    end else if (stop_evt) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      byte_idx   <= '0;
      rd_mode    <= 1'b0;
      rd_pending <= 1'b0;
      wr_pending <= 1'b0;
      sda_oe_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise && bitcnt != BITS_FULL) begin
            rx_sr  <= {rx_sr[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_evt) begin
            if (byte_idx != 3'd7) byte_idx <= byte_idx + 1'b1;
            unique case (byte_idx)
              3'd0: if (go_read) rd_mode <= 1'b1;
              3'd1: begin
                cfg_sel <= rx_sr[7];
                arg_blk <= rx_sr[4:1];
              end
              3'd3: if (cfg_sel) begin
                if (rx_sr[6] && rx_sr[7] || rx_sr[6] && !rx_sr[7]) begin
                  rd_pending <= 1'b1;
                  rd_prot    <= rx_sr[7];
                end else if (write_cmd_ok(rx_sr)) begin
                  wr_pending <= 1'b1;
                  wr_prot    <= rx_sr[7];
                  arg_cnt    <= rx_sr[3:0];
                end
              end
              default: ;
            endcase
            if (byte_ack) begin
              state    <= ST_ACK;
              sda_oe_q <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rd_mode) begin
            state    <= ST_TX;
            tx_sr    <= first_reply;
            sda_oe_q <= ~first_reply[7];
            tx_last  <= ~rd_prot;
          end else begin
            state    <= ST_RX;
            sda_oe_q <= 1'b0;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bitcnt == LAST_TX) begin
            state    <= ST_MACK;
            sda_oe_q <= 1'b0;
          end else begin
            bitcnt   <= bitcnt + 1'b1;
            tx_sr    <= {tx_sr[6:0], 1'b1};
            sda_oe_q <= ~tx_sr[6];
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          if (scl_fall) begin
            bitcnt <= '0;
            if (mack_ok && !tx_last) begin
              state    <= ST_TX;
              tx_sr    <= second_reply;
              sda_oe_q <= ~second_reply[7];
              tx_last  <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end

  assign sda_oe = sda_oe_q;

  i2ccfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_prot(wr_prot),
    .blk_arg(arg_blk), .cnt_arg(arg_cnt),
    .prot_start(prot_start), .prot_cnt(prot_cnt), .he_blk(he_blk)
  );
endmodule

// File: rtl/i2c_cfg_engine_chk.sv
module i2c_cfg_engine_chk
  import i2ccfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             stop_evt,
  input logic             byte_evt,
  input logic             ctrl_ok,
  input logic [2:0]       byte_idx,
  input logic             in_idle,
  input logic             tx_active,
  input logic [3:0]       bitcnt,
  input logic [BLK_W-1:0] prot_start,
  input logic [BLK_W-1:0] prot_cnt,
  input logic [BLK_W-1:0] he_blk
);
  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R7
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({prot_start, prot_cnt, he_blk}) |-> $past(stop_evt));

  // R5
  reply_high_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && bitcnt < 4'd4) |-> !sda_oe);

  // R9
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  // R1
  foreign_ctrl_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && byte_idx == 3'd0 && !ctrl_ok) |=> !sda_oe);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

bind i2c_cfg_engine i2c_cfg_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .stop_evt(stop_evt),
  .byte_evt(byte_evt), .ctrl_ok(ctrl_ok), .byte_idx(byte_idx), .in_idle(in_idle),
  .tx_active(tx_active), .bitcnt(bitcnt), .prot_start(prot_start),
  .prot_cnt(prot_cnt), .he_blk(he_blk)
);

// File: tb/i2c_cfg_engine_test.sv
module i2c_cfg_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] pins = 3'd0;
  logic sda_oe;
  logic [3:0] prot_start, prot_cnt, he_blk;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int hi_changes = 0;
  logic [3:0] m_start = 0, m_cnt = 0, m_he = 0;

  always #5 clk = ~clk;

  i2c_cfg_engine uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .addr_sel(pins),
    .sda_oe(sda_oe), .prot_start(prot_start), .prot_cnt(prot_cnt), .he_blk(he_blk)
  );

  // R11 monitor: output enable must not move while SCL is high
  always @(sda_oe) if (rst_n && scl_m) hi_changes++;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [7:0] ctrl(input logic [2:0] p, input logic rw);
    return {4'b1010, p, rw};
  endfunction
  function automatic logic [7:0] exp_reply(input logic [3:0] nib);
    return {4'hF, nib};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q(input int n = 1);
    repeat (5 * n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask
  task automatic bus_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q(2); scl_m = 0; q();
    end
    sda_m = 1; q(); scl_m = 1; q(); ack_n = sda_bus; q(); scl_m = 0; q();
  endtask
  task automatic recv_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; q(); scl_m = 1; q(); b[i] = sda_bus; q(); scl_m = 0; q();
    end
    sda_m = nack; q(); scl_m = 1; q(2); scl_m = 0; q();
    sda_m = 1;
  endtask

  // four-byte configuration write; acks checked against R2
  task automatic cfg_write(input logic [7:0] a1, input logic [7:0] a0,
                           input logic [7:0] cmd, input logic do_stop);
    logic a;
    bus_start();
    send_byte(ctrl(pins, 1'b0), a); check("R2 ctrl ack", a, 0);
    send_byte(a1, a);  check("R2 addr1 ack", a, 0);
    send_byte(a0, a);  check("R2 addr0 ack", a, 0);
    send_byte(cmd, a); check("R2 cmd ack", a, 0);
    if (do_stop) bus_stop();
  endtask

  task automatic read_prot(input string tag);
    logic a; logic [7:0] b0, b1;
    bus_start();
    send_byte(ctrl(pins, 1'b0), a);
    send_byte(8'h80, a);
    send_byte(8'h00, a);
    send_byte({2'b11, 6'($urandom)}, a);
    bus_start();
    send_byte(ctrl(pins, 1'b1), a); check({tag, " R9 read ctrl ack"}, a, 0);
    recv_byte(1'b0, b0);
    recv_byte(1'b1, b1);
    check({tag, " R5 first byte"}, b0, exp_reply(m_start));
    check({tag, " R5 second byte"}, b1, exp_reply(m_cnt));
    q(); check({tag, " R9 released after nack"}, sda_oe, 0);
    bus_stop();
  endtask

  task automatic read_end(input string tag);
    logic a; logic [7:0] b0;
    bus_start();
    send_byte(ctrl(pins, 1'b0), a);
    send_byte(8'h80, a);
    send_byte(8'h00, a);
    send_byte({2'b01, 6'($urandom)}, a);
    bus_start();
    send_byte(ctrl(pins, 1'b1), a);
    recv_byte(1'b1, b0);
    check({tag, " R6 endurance byte"}, b0, exp_reply(m_he));
    bus_stop();
  endtask

  task automatic check_outputs(input string tag);
    q(2);
    check({tag, " start"}, prot_start, m_start);
    check({tag, " count"}, prot_cnt, m_cnt);
    check({tag, " endurance"}, he_blk, m_he);
  endtask

  task automatic prot_write(input logic [3:0] s, input logic [3:0] c);
    logic [1:0] x = 2'($urandom);
    cfg_write({1'b1, x, s, x[0]}, 8'($urandom), {2'b10, x, c}, 1'b1);
    m_start = s; m_cnt = c;
  endtask

  task automatic end_write(input logic [3:0] blk);
    logic [1:0] x = 2'($urandom);
    cfg_write({1'b1, x, blk, x[1]}, 8'($urandom), {2'b00, x, 4'h0}, 1'b1);
    m_he = blk;
  endtask

  initial begin
    logic a;
    int seed;
    seed = $urandom(32'd2024);
    pins = 3'b101;
    repeat (4) @(negedge clk);
    // R8 reset state
    check("R8 sda_oe in reset", sda_oe, 0);
    rst_n = 1;
    q(2);
    check_outputs("R8 reset");
    check("R8 sda_oe idle", sda_oe, 0);

    // R3 protection write; R7 nothing before stop
    cfg_write({1'b1, 2'b00, 4'd5, 1'b0}, 8'h3C, 8'h89, 1'b0);
    q(2); check("R7 no change before stop", prot_cnt, 0);
    bus_stop();
    m_start = 5; m_cnt = 9;
    check_outputs("R3 prot write");
    read_prot("R5 dir");

    // R4 endurance write and read
    end_write(4'd12);
    check_outputs("R4 end write");
    read_end("R6 dir");

    // R4 nonzero low nibble ignored
    cfg_write({1'b1, 2'b00, 4'd3, 1'b0}, 8'h00, 8'h03, 1'b1);
    check_outputs("R4 bad nibble ignored");
    read_end("R4 bad nibble");

    // R1 foreign device select
    bus_start();
    send_byte(ctrl(~pins, 1'b0), a); check("R1 foreign ctrl nack", a, 1);
    send_byte({1'b1, 2'b00, 4'd1, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    bus_stop();
    check_outputs("R1 no change");
    bus_start();
    send_byte(8'hB0 | {4'h0, pins, 1'b0}, a); check("R1 wrong code nack", a, 1);
    bus_stop();

    // R7 repeated start instead of stop
    cfg_write({1'b1, 2'b00, 4'd7, 1'b0}, 8'h00, 8'h8E, 1'b0);
    bus_start();
    bus_stop();
    check_outputs("R7 repeated start");
    // R7 stop before command byte
    bus_start();
    send_byte(ctrl(pins, 1'b0), a);
    send_byte({1'b1, 2'b00, 4'd2, 1'b0}, a);
    send_byte(8'h00, a);
    bus_stop();
    check_outputs("R7 missing cmd");

    // R9 read control with nothing pending
    bus_start();
    send_byte(ctrl(pins, 1'b1), a); check("R9 read without command nack", a, 1);
    bus_stop();

    // R10 normal access
    cfg_write({1'b0, 2'b00, 4'd6, 1'b1}, 8'h12, 8'h84, 1'b0);
    send_byte(8'h55, a); check("R10 data ack", a, 0);
    bus_stop();
    check_outputs("R10 normal access");

    // random mix
    for (int it = 0; it < 16; it++) begin
      pins = 3'($urandom);
      case ($urandom % 3)
        0: prot_write(4'($urandom), 4'($urandom));
        1: end_write(4'($urandom));
        default: cfg_write({1'b1, 2'b00, 4'($urandom), 1'b0}, 8'h00,
                           {2'b00, 2'b11, 4'($urandom % 15 + 1)}, 1'b1);
      endcase
      check_outputs("R3 R4 random");
      if (it % 2 == 0) read_prot("R5 random");
      else             read_end("R6 random");
    end

    check("R11 sda_oe changes while SCL high", hi_changes, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule